// File: doc/BRIEF.md
# Fringe Amplitude and Quadrature Correlator

This block takes one profile of detrended fringe samples, one signed sample per accepted cycle, and in a single pass produces three figures for that profile. The first is the fringe amplitude: half the spread between the largest and the smallest sample. The other two are correlation sums. Each sample is multiplied by a per-pixel-index sine coefficient and by a per-pixel-index cosine coefficient, and the products are accumulated. The coefficients describe the profile's fixed fringe frequency. A downstream phase search uses the three results.

The two coefficient tables are small memories with one signed fixed-point entry per pixel index. They are filled through a simple write port before acquisition starts. A profile is `NUM_PIX` samples long. The sample position counts from zero in arrival order and selects the coefficient that is read. A start flag on a sample forces that sample to be position zero. All three results appear together with a one-cycle valid strobe.

Top module: `fringe_correlator`

## Requirements
- R1: After reset `res_valid_o` is low and `amp_o`, `sin_sum_o` and `cos_sum_o` are zero.
- R2: `res_valid_o` is high for exactly one cycle, in the cycle after the clock edge that accepts the sample at position `NUM_PIX-1`. Idle cycles (`smp_valid_i` low) between samples do not affect the results.
- R3: `amp_o` equals (maximum − minimum) of the profile's samples, shifted right by one bit (rounded down).
- R4: The maximum and the minimum start over from the sample at position 0 of each profile, so no value from an earlier profile affects `amp_o`.
- R5: `sin_sum_o` is the sum over positions i of sample[i] × sine_entry[i].
- R6: `cos_sum_o` is the sum over positions i of sample[i] × cosine_entry[i].
- R7: While `tbl_we_i` is high, `tbl_data_i` is written to entry `tbl_addr_i`. `tbl_sel_i` = 0 selects the sine table and 1 selects the cosine table. A write to one table leaves the other table unchanged.
- R8: A sample with `smp_first_i` high becomes position 0. Any partially received profile is discarded and produces no result.
- R9: The accumulators are wide enough that a profile of full-scale negative samples and full-scale negative coefficients gives the exact sum `NUM_PIX`·2^(2·W−2), where W is the sample width and the coefficient width.
- R10: Between strobes the three result outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Coefficient write enable |
| tbl_sel_i | input | 1 | Table select: 0 selects sine, 1 selects cosine |
| tbl_addr_i | input | IDX_W | Pixel index of the entry to write |
| tbl_data_i | input | COEF_W | Signed coefficient to write |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_first_i | input | 1 | Sample is position 0 of a new profile |
| smp_data_i | input | SMP_W | Signed rectified sample |
| res_valid_o | output | 1 | One-cycle result strobe |
| amp_o | output | SMP_W | Fringe amplitude |
| sin_sum_o | output | ACC_W | Signed sine correlation sum |
| cos_sum_o | output | ACC_W | Signed cosine correlation sum |

## Verification
The hardest case to reach is a profile that is abandoned partway through and then restarted. This case has to show that neither the extrema nor the accumulators carry anything over. The stimulus sends a few samples with values far outside the range of the following profile, then asserts the start flag and sends a full profile. Exactly one result must come out, and it must match the clean profile. Idle gaps are placed between samples, and one table is rewritten between profiles, so the index counter and the table select are both exercised. A profile at full negative scale pushes the accumulators to their largest magnitude.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic {
    TBL_SINE   = 1'b0,
    TBL_COSINE = 1'b1
  } tbl_sel_e;
endpackage

// File: rtl/coef_table.sv
module coef_table #(
  parameter int DEPTH  = 20,
  parameter int DATA_W = 18,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        waddr_i,
  input  logic signed [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]        raddr_i,
  output logic signed [DATA_W-1:0] rdata_o
);
  logic signed [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && (32'(waddr_i) < DEPTH)) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = (32'(raddr_i) < DEPTH) ? mem_q[raddr_i] : '0;

  // R7: a written entry reads back on the next cycle
  a_r7_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (32'(waddr_i) < DEPTH)) |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/extrema_tracker.sv
module extrema_tracker #(
  parameter int W = 18
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                init_i,
  input  logic signed [W-1:0] data_i,
  output logic [W-1:0]        amp_o
);
  logic signed [W-1:0] max_q, min_q, max_n, min_n;
  logic signed [W:0]   span;

  always_comb begin
    max_n = (init_i || data_i > max_q) ? data_i : max_q;
    min_n = (init_i || data_i < min_q) ? data_i : min_q;
    span  = (W+1)'(max_n) - (W+1)'(min_n);
  end

  assign amp_o = W'(span >>> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_q <= '0;
      min_q <= '0;
    end else if (valid_i) begin
      max_q <= max_n;
      min_q <= min_n;
    end
  end

  a_r3_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i) |-> (max_q >= min_q));
  a_r4_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && init_i) |=> (max_q == min_q));
endmodule

// File: rtl/corr_mac.sv
module corr_mac #(
  parameter int SMP_W  = 18,
  parameter int COEF_W = 18,
  parameter int ACC_W  = 41,
  localparam int PROD_W = SMP_W + COEF_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     init_i,
  input  logic signed [SMP_W-1:0]  smp_i,
  input  logic signed [COEF_W-1:0] coef_i,
  output logic signed [ACC_W-1:0]  sum_n_o
);
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_x, acc_q;

  assign prod    = PROD_W'(smp_i) * PROD_W'(coef_i);
  assign prod_x  = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  assign sum_n_o = init_i ? prod_x : acc_q + prod_x;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (valid_i) acc_q <= sum_n_o;
  end

  // R9: adding same-signed terms never flips the sign
  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !init_i && (acc_q[ACC_W-1] == prod_x[ACC_W-1]) && (prod != '0))
      |-> (sum_n_o[ACC_W-1] == acc_q[ACC_W-1]));
endmodule

// File: rtl/fringe_correlator.sv
module fringe_correlator
  import fc_pkg::*;
#(
  parameter int NUM_PIX = 20,
  parameter int SMP_W   = 18,
  parameter int COEF_W  = 18,
  localparam int IDX_W  = $clog2(NUM_PIX),
  localparam int ACC_W  = SMP_W + COEF_W + $clog2(NUM_PIX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tbl_we_i,
  input  logic              tbl_sel_i,
  input  logic [IDX_W-1:0]  tbl_addr_i,
  input  logic [COEF_W-1:0] tbl_data_i,
  input  logic              smp_valid_i,
  input  logic              smp_first_i,
  input  logic [SMP_W-1:0]  smp_data_i,
  output logic              res_valid_o,
  output logic [SMP_W-1:0]  amp_o,
  output logic [ACC_W-1:0]  sin_sum_o,
  output logic [ACC_W-1:0]  cos_sum_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PIX - 1);

  logic [IDX_W-1:0] cnt_q, idx;
  logic             init, last;
  logic [SMP_W-1:0] amp_n;
  logic signed [ACC_W-1:0] sum_n [2];

  assign idx  = smp_first_i ? '0 : cnt_q;
  assign init = (idx == '0);
  assign last = smp_valid_i && (idx == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (smp_valid_i) cnt_q <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
  end

  extrema_tracker #(.W(SMP_W)) u_ext (
    .clk_i, .rst_ni,
    .valid_i(smp_valid_i), .init_i(init),
    .data_i($signed(smp_data_i)), .amp_o(amp_n)
  );

  for (genvar k = 0; k < 2; k++) begin : g_chan
    localparam logic CODE = (k == 0) ? TBL_SINE : TBL_COSINE;
    logic signed [COEF_W-1:0] coef;

    coef_table #(.DEPTH(NUM_PIX), .DATA_W(COEF_W)) u_tbl (
      .clk_i, .rst_ni,
      .we_i(tbl_we_i && (tbl_sel_i == CODE)),
      .waddr_i(tbl_addr_i), .wdata_i($signed(tbl_data_i)),
      .raddr_i(idx), .rdata_o(coef)
    );

    corr_mac #(.SMP_W(SMP_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
      .clk_i, .rst_ni,
      .valid_i(smp_valid_i), .init_i(init),
      .smp_i($signed(smp_data_i)), .coef_i(coef),
      .sum_n_o(sum_n[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      amp_o       <= '0;
      sin_sum_o   <= '0;
      cos_sum_o   <= '0;
    end else begin
      res_valid_o <= last;
      if (last) begin
        amp_o     <= amp_n;
        sin_sum_o <= sum_n[0];
        cos_sum_o <= sum_n[1];
      end
    end
  end

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (NUM_PIX > 1 && res_valid_o) |=> !res_valid_o);
  a_r2_after_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(smp_valid_i));
  a_r3_amp_nonneg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !amp_o[SMP_W-1]);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> ($stable(amp_o) && $stable(sin_sum_o) && $stable(cos_sum_o)));
  a_r8_index_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < NUM_PIX);
endmodule

// File: tb/fringe_correlator_test.sv
module fringe_correlator_test;
  localparam int NUM_PIX = 20;
  localparam int SMP_W   = 18;
  localparam int COEF_W  = 18;
  localparam int IDX_W   = $clog2(NUM_PIX);
  localparam int ACC_W   = SMP_W + COEF_W + $clog2(NUM_PIX);

  typedef struct {
    longint amp;
    longint s;
    longint c;
    string  tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic tbl_we = 0, tbl_sel = 0;
  logic [IDX_W-1:0] tbl_addr = '0;
  logic [COEF_W-1:0] tbl_data = '0;
  logic smp_valid = 0, smp_first = 0;
  logic [SMP_W-1:0] smp_data = '0;
  logic res_valid;
  logic [SMP_W-1:0] amp;
  logic [ACC_W-1:0] sin_sum, cos_sum;

  int checks = 0, failures = 0;
  bit done = 0;
  exp_t sb[$];
  exp_t last_exp;
  longint sin_m[NUM_PIX], cos_m[NUM_PIX], smp[NUM_PIX];

  always #5 clk = ~clk;

  fringe_correlator #(.NUM_PIX(NUM_PIX), .SMP_W(SMP_W), .COEF_W(COEF_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .tbl_we_i(tbl_we), .tbl_sel_i(tbl_sel), .tbl_addr_i(tbl_addr), .tbl_data_i(tbl_data),
    .smp_valid_i(smp_valid), .smp_first_i(smp_first), .smp_data_i(smp_data),
    .res_valid_o(res_valid), .amp_o(amp), .sin_sum_o(sin_sum), .cos_sum_o(cos_sum)
  );

  task automatic check(input string tag, input string what, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic longint sx(input logic [ACC_W-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic write_tbl(input bit sel, input int addr, input longint val);
    @(negedge clk);
    tbl_we = 1; tbl_sel = sel; tbl_addr = IDX_W'(addr); tbl_data = COEF_W'(val);
    if (sel) cos_m[addr] = val; else sin_m[addr] = val;
    @(negedge clk);
    tbl_we = 0;
  endtask

  // driver: computes expectation from smp[] and bench tables, then streams
  task automatic send_profile(input string tag, input int gap);
    exp_t e;
    longint mx, mn, s, c;
    mx = smp[0]; mn = smp[0]; s = 0; c = 0;
    for (int i = 0; i < NUM_PIX; i++) begin
      if (smp[i] > mx) mx = smp[i];
      if (smp[i] < mn) mn = smp[i];
      s += smp[i] * sin_m[i];
      c += smp[i] * cos_m[i];
    end
    e.amp = (mx - mn) >>> 1; e.s = s; e.c = c; e.tag = tag;
    sb.push_back(e);
    last_exp = e;
    for (int i = 0; i < NUM_PIX; i++) begin
      @(negedge clk);
      smp_valid = 1; smp_first = (i == 0); smp_data = SMP_W'(smp[i]);
      if (gap > 0 && i != NUM_PIX - 1) begin
        @(negedge clk);
        smp_valid = 0; smp_first = 0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    smp_valid = 0; smp_first = 0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && res_valid) begin
        if (sb.size() == 0) begin
          checks++; failures++;
          $display("FAIL R2 unexpected result: got strobe expected none");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({"R3 ", e.tag}, "amplitude", longint'(amp), e.amp);
          check({"R5 ", e.tag}, "sine sum", sx(sin_sum), e.s);
          check({"R6 ", e.tag}, "cosine sum", sx(cos_sum), e.c);
          @(negedge clk);
          check({"R2 ", e.tag}, "strobe width", longint'(res_valid), 0);
        end
      end
    end
  end

  task automatic wait_drain();
    repeat (4) @(negedge clk);
    check("R2", "pending results", longint'(sb.size()), 0);
  endtask

  task automatic check_hold(input string tag);
    repeat (5) @(negedge clk);
    check(tag, "R10 strobe idle", longint'(res_valid), 0);
    check(tag, "R10 amplitude held", longint'(amp), last_exp.amp);
    check(tag, "R10 sine held", sx(sin_sum), last_exp.s);
    check(tag, "R10 cosine held", sx(cos_sum), last_exp.c);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "strobe", longint'(res_valid), 0);
    check("R1", "amplitude", longint'(amp), 0);
    check("R1", "sine sum", sx(sin_sum), 0);
    check("R1", "cosine sum", sx(cos_sum), 0);
    rst_n = 1;

    // R7 load tables with a fringe of period 5 pixels
    for (int i = 0; i < NUM_PIX; i++) begin
      write_tbl(1'b0, i, longint'($rtoi($floor($sin(6.283185307 * 0.2 * i) * 131071.0 + 0.5))));
      write_tbl(1'b1, i, longint'($rtoi($floor($cos(6.283185307 * 0.2 * i) * 131071.0 + 0.5))));
    end

    // R5/R6 cosine-like profile, back to back
    for (int i = 0; i < NUM_PIX; i++) smp[i] = longint'((i % 5) * 3000 - 6000 + i * 11);
    send_profile("R5", 0);
    wait_drain();
    check_hold("R10");

    // R2 idle gaps between samples
    for (int i = 0; i < NUM_PIX; i++) smp[i] = longint'(((i * 37) % 23) * 500 - 5000);
    send_profile("R2", 3);
    wait_drain();

    // R8 abandoned partial profile, then restart
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      smp_valid = 1; smp_first = (i == 0); smp_data = SMP_W'(i % 2 ? 131071 : -131072);
    end
    for (int i = 0; i < NUM_PIX; i++) smp[i] = longint'(i * 100 - 700);
    send_profile("R8", 0);
    wait_drain();

    // R4 previous profile had wide span; this one is narrow
    for (int i = 0; i < NUM_PIX; i++) smp[i] = longint'(40 + (i % 3));
    send_profile("R4", 1);
    wait_drain();

    // R3 extreme span, odd difference rounds down
    for (int i = 0; i < NUM_PIX; i++) smp[i] = (i == 7) ? 131071 : ((i == 12) ? -131072 : longint'(i));
    send_profile("R3", 0);
    wait_drain();

    // R7 rewrite only the sine table; cosine table must be unchanged
    for (int i = 0; i < NUM_PIX; i++) write_tbl(1'b0, i, longint'(i * 1000 - 9000));
    for (int i = 0; i < NUM_PIX; i++) smp[i] = longint'(i * 250 - 2500);
    send_profile("R7", 0);
    wait_drain();

    // R9 full negative scale
    for (int i = 0; i < NUM_PIX; i++) begin
      write_tbl(1'b0, i, -131072);
      write_tbl(1'b1, i, -131072);
      smp[i] = -131072;
    end
    send_profile("R9", 0);
    wait_drain();
    check("R9", "exact full-scale sine", sx(sin_sum), longint'(NUM_PIX) * (64'sd1 <<< 34));
    check_hold("R9");

    done = 1;
    finish_run();
  end
endmodule